// File: doc/BRIEF.md
# Serial DAC Input Register Pair

This block is the digital front end of a 16-bit serial-input converter. A host shifts a code in one bit per serial-clock rising edge while the active-low select is held low. When the select returns high, the collected word is copied into a separate output register, and that register drives the converter code.

The serial pins are sampled against a fast system clock. Each pin passes through a short synchroniser, and edges are detected on the synchronised levels. A power-on reset input clears the output register only. The serial shift register keeps whatever it held before, so a select rise that comes after power-up without a fresh write transfers stale bits to the output.

For simulation, a preload input forces arbitrary content into the shift register, standing in for charge retained across a power cycle. A host that powers up with the select low can flush the shift register by clocking in sixteen zero bits before it raises the select.

Top module: `sdac_front`

## Requirements
- R1: While `por` is high, `dac_code` is 0x0000. The clear is asynchronous and takes effect without a `clk` edge.
- R2: Asserting or releasing `por` leaves `shift_obs` unchanged.
- R3: `dac_code` changes only when a low-to-high transition of the synchronised `cs_n` is detected. It then takes the value `shift_obs` held in that cycle.
- R4: On each synchronised `sclk` rising edge with synchronised `cs_n` low, the shift register moves one place toward bit 15 and takes `din` into bit 0. A word therefore enters MSB first.
- R5: `sclk` edges while `cs_n` is high leave `shift_obs` and `dac_code` unchanged.
- R6: When a frame has more than 16 bits, the last 16 bits received are latched. When a frame has fewer, the older shift content fills the upper bits.
- R7: If `cs_n` is already low when `por` is released, the next `cs_n` rise loads the retained shift content into `dac_code`.
- R8: With `cs_n` low, sixteen `sclk` pulses with `din` low make `shift_obs` 0x0000, and a following `cs_n` rise loads 0x0000.
- R9: If `cs_n` stays high through power-up, `dac_code` stays 0x0000 until a write completes with a `cs_n` rise.
- R10: While `preload_en` is high, the shift register takes `preload_val` at each `clk` edge. Preload takes priority over shifting, and `por` does not block it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for sampling and all registers |
| por | input | 1 | Active-high asynchronous power-on reset |
| cs_n | input | 1 | Active-low frame select; its rise latches the word |
| sclk | input | 1 | Serial bit clock; sampled on its rising edge |
| din | input | 1 | Serial data bit |
| preload_en | input | 1 | Simulation-only shift register force enable |
| preload_val | input | 16 | Value forced into the shift register |
| dac_code | output | 16 | Output data register, drives the converter |
| shift_obs | output | 16 | Observation of the serial shift register |

## Verification
A wrong bit position or shift direction shows on `shift_obs` within three `clk` cycles of the `sclk` edge that caused it. The same error reaches `dac_code` three cycles after the next `cs_n` rise. A reset that wrongly reaches the shift register shows at once on `shift_obs` while `por` is high, and a transfer of that cleared value shows after the first select rise. A spurious or missed edge detection shifts every later bit by one place, so the sweeps over single-bit words and frames of 1 to 20 bits expose it with the first affected frame.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    // Synchronised serial pin levels
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic din;
    } pins_t;

    // History used for edge detection
    typedef struct packed {
        logic cs_n;
        logic sclk;
    } hist_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, din: 1'b0};
    localparam hist_t HIST_IDLE = '{cs_n: 1'b1, sclk: 1'b0};

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync
    import sdac_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  por,
    input  pins_t raw,
    output pins_t sync
);
    pins_t stg_d [STAGES];
    pins_t stg_q [STAGES];

    always_comb stg_d[0] = raw;

    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_comb stg_d[g] = stg_q[g-1];
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_reg
        always_ff @(posedge clk or posedge por) begin
            if (por) stg_q[g] <= PINS_IDLE;
            else     stg_q[g] <= stg_d[g];
        end
    end

    assign sync = stg_q[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
    import sdac_pkg::*;
(
    input  logic  clk,
    input  logic  por,
    input  pins_t lvl,
    output logic  cs_rise,
    output logic  sh_en
);
    hist_t prev_d, prev_q;

    always_comb begin
        prev_d.cs_n = lvl.cs_n;
        prev_d.sclk = lvl.sclk;
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) prev_q <= HIST_IDLE;
        else     prev_q <= prev_d;
    end

    assign cs_rise = lvl.cs_n & ~prev_q.cs_n;
    assign sh_en   = lvl.sclk & ~prev_q.sclk & ~lvl.cs_n;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         sh_en,
    input  logic         bit_in,
    input  logic         pre_en,
    input  logic [W-1:0] pre_val,
    output logic [W-1:0] q
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (pre_en)     sr_d = pre_val;
        else if (sh_en) sr_d = {sr_q[W-2:0], bit_in};
    end

    // No reset: content survives power-on reset by design
    always_ff @(posedge clk) sr_q <= sr_d;

    assign q = sr_q;
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         por,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (load) code_d = d;
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) code_q <= '0;
        else     code_q <= code_d;
    end

    assign q = code_q;
endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         por,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         din,
    input  logic         preload_en,
    input  logic [W-1:0] preload_val,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] shift_obs
);
    pins_t pin_raw, pin_s;
    logic  cs_rise, sh_en, bit_s;

    always_comb begin
        pin_raw.cs_n = cs_n;
        pin_raw.sclk = sclk;
        pin_raw.din  = din;
    end

    sdac_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .por(por), .raw(pin_raw), .sync(pin_s)
    );

    sdac_edge u_edge (
        .clk(clk), .por(por), .lvl(pin_s), .cs_rise(cs_rise), .sh_en(sh_en)
    );

    assign bit_s = pin_s.din;

    sdac_shift #(.W(W)) u_shift (
        .clk(clk), .sh_en(sh_en), .bit_in(bit_s),
        .pre_en(preload_en), .pre_val(preload_val), .q(shift_obs)
    );

    sdac_hold #(.W(W)) u_hold (
        .clk(clk), .por(por), .load(cs_rise), .d(shift_obs), .q(dac_code)
    );
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         por,
    input logic         cs_rise,
    input logic         sh_en,
    input logic         bit_s,
    input logic         preload_en,
    input logic [W-1:0] preload_val,
    input logic [W-1:0] dac_code,
    input logic [W-1:0] shift_obs
);
    // R1
    always @(posedge clk) begin
        if (por === 1'b1) begin
            por_clear_chk: assert (dac_code == '0);
        end
    end

    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (por)
        !cs_rise |=> $stable(dac_code));

    // R3
    code_load_chk: assert property (@(posedge clk) disable iff (por)
        cs_rise |=> dac_code == $past(shift_obs));

    // R4
    shift_step_chk: assert property (@(posedge clk) disable iff (por)
        (sh_en && !preload_en) |=> shift_obs == {$past(shift_obs[W-2:0]), $past(bit_s)});

    // R5
    shift_idle_chk: assert property (@(posedge clk) disable iff (por)
        (!sh_en && !preload_en) |=> $stable(shift_obs));

    // R10
    preload_chk: assert property (@(posedge clk) disable iff (por)
        preload_en |=> shift_obs == $past(preload_val));
endmodule

bind sdac_front sdac_front_chk #(.W(W)) u_chk (
    .clk(clk), .por(por), .cs_rise(cs_rise), .sh_en(sh_en), .bit_s(bit_s),
    .preload_en(preload_en), .preload_val(preload_val),
    .dac_code(dac_code), .shift_obs(shift_obs)
);

// File: tb/sim_sdac_front.sv
module sim_sdac_front;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         por = 1'b1;
    logic         cs_n = 1'b0;
    logic         sclk = 1'b0;
    logic         din = 1'b0;
    logic         preload_en = 1'b0;
    logic [W-1:0] preload_val = '0;
    logic [W-1:0] dac_code, shift_obs;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_sr;

    always #5 clk = ~clk;

    sdac_front #(.W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .por(por), .cs_n(cs_n), .sclk(sclk), .din(din),
        .preload_en(preload_en), .preload_val(preload_val),
        .dac_code(dac_code), .shift_obs(shift_obs)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Send n bits of val, MSB of the n first; update bench model
    task automatic send(input logic [31:0] val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            din = val[i];
            tick(4);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            if (!cs_n) exp_sr = {exp_sr[W-2:0], val[i]};
        end
        tick(6);
    endtask

    task automatic frame(input logic [31:0] val, input int n);
        cs_n = 1'b0;
        tick(6);
        send(val, n);
        cs_n = 1'b1;
        tick(6);
    endtask

    task automatic do_preload(input logic [W-1:0] v);
        preload_val = v;
        preload_en  = 1'b1;
        tick(2);
        preload_en  = 1'b0;
        exp_sr      = v;
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Power-up with cs_n low and retained content
        exp_sr = '0;
        tick(2);
        do_preload(16'hA5C3);
        chk("R1 reset state", dac_code, 16'h0000);
        chk("R10 preload during reset", shift_obs, 16'hA5C3);
        por = 1'b0;
        tick(6);
        chk("R2 release keeps shift", shift_obs, 16'hA5C3);
        chk("R7 no load before rise", dac_code, 16'h0000);
        cs_n = 1'b1;
        tick(6);
        chk("R7 stale content latched", dac_code, 16'hA5C3);

        // Asynchronous clear mid-cycle
        @(posedge clk);
        #2 por = 1'b1;
        #1 chk("R1 async clear", dac_code, 16'h0000);
        tick(3);
        chk("R2 reset keeps shift", shift_obs, 16'hA5C3);

        // Power-up with cs_n high
        do_preload(16'h1234);
        por = 1'b0;
        tick(6);
        chk("R9 code zero after powerup", dac_code, 16'h0000);
        cs_n = 1'b1;
        tick(4);
        send(32'h0000_FFFF, 16);
        chk("R5 sclk ignored while deselected", shift_obs, 16'h1234);
        chk("R5 code unchanged", dac_code, 16'h0000);
        cs_n = 1'b0;
        tick(6);
        send(32'h0000_BEEF, 16);
        chk("R4 full word shifted", shift_obs, 16'hBEEF);
        chk("R9 no load before rise", dac_code, 16'h0000);
        cs_n = 1'b1;
        tick(6);
        chk("R3 load on rise", dac_code, 16'hBEEF);

        // Sweep single-bit words and their complements
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] w;
            w = W'(1) << k;
            frame({16'h0, w}, 16);
            chk("R4 one-hot position", dac_code, w);
            frame({16'h0, ~w}, 16);
            chk("R4 one-cold position", dac_code, ~w);
        end

        // Short and long frames
        for (int n = 1; n <= 20; n++) begin
            logic [31:0] v;
            v = 32'h9E37_79B9 * n;
            frame(v, n);
            chk("R6 partial/over frame", dac_code, exp_sr);
        end

        // Flush with sixteen zeros
        frame(32'h0000_C0DE, 16);
        chk("R3 nonzero before flush", dac_code, 16'hC0DE);
        cs_n = 1'b0;
        tick(6);
        do_preload(16'hFFFF);
        send(32'h0, 16);
        chk("R8 shift flushed", shift_obs, 16'h0000);
        chk("R3 held during frame", dac_code, 16'hC0DE);
        cs_n = 1'b1;
        tick(6);
        chk("R8 zero loaded", dac_code, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule